// File: doc/BRIEF.md
# Interrupt Pending Identification Register

This block condenses the interrupt state of six register modules and one system group into a single read-only byte. Software reads that byte to learn which groups hold a source that needs service. It then inspects only those groups. Each module group holds eight sources, and each source has a latched flag and an enable bit. The system group holds four sources, such as a watchdog timeout. It has per-source enables and also a global system-interrupt enable.

Hardware raises a flag with a one-cycle event pulse. Software loads enable masks, or clears flags by writing ones, through a single write port. That port is selected by a group index and a write kind. The identification byte is registered once. A change in flags or enables therefore appears on the read port one cycle after the storage changes, which is two clock edges after the event or write is presented. The byte cannot be written, and its bit 6 is a hole that always reads zero.

Top module: `irq_pend_id`

## Requirements
- R1: Bit g of `id_o` (g = 0..5) becomes 1 when module group g has a source with both flag and enable set. The bit changes on the second rising edge after the event or write is presented.
- R2: Bit 7 of `id_o` becomes 1 when a system source has its flag and its enable set while the global system enable is 1.
- R3: A flagged source whose enable is 0 does not set its group's pending bit.
- R4: Loading an enable mask that excludes every flagged source in a group clears that group's pending bit, while the flags stay stored.
- R5: A write with `wr_sel_i`=g and `wr_clr_i`=1 clears each flag of group g whose `wr_data_i` bit is 1, and leaves flags whose data bit is 0 unchanged. `wr_sel_i`=6 clears the system flags from `wr_data_i[3:0]`.
- R6: Bit 6 of `id_o` always reads 0.
- R7: Reset clears `id_o` to 00h and clears all flags, enables and the global system enable.
- R8: A one-cycle pulse on `evt_i[8*g+b]` (or `sys_evt_i[b]`) sets that flag. The flag stays set until software clears it.
- R9: When an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: With the global system enable at 0, bit 7 stays 0 whatever the system flags and enables are.
- R11: A write with `wr_sel_i`=7 changes no flag or enable. With `wr_clr_i`=0, `wr_sel_i`=g loads group g's enables from `wr_data_i`. `wr_sel_i`=6 loads the system enables from `wr_data_i[3:0]` and the global enable from `wr_data_i[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 48 | Event pulses, bit 8*g+b sets flag b of module group g |
| sys_evt_i | input | 4 | Event pulses for the system group flags |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 3 | Target group: 0..5 module groups, 6 system, 7 none |
| wr_clr_i | input | 1 | Write kind: 0 loads enables, 1 clears flags where data is 1 |
| wr_data_i | input | 8 | Write data |
| id_o | output | 8 | Identification byte: bits 0..5 modules, bit 6 zero, bit 7 system |

## Verification
The hardest state to reach is a flag that an event sets in the same cycle as software clears it. It has to be told apart from a flag that was never cleared. The stimulus table first makes that group pending. It then presents the event and a full clear together, and expects the bit to stay set. The next row repeats the clear with no event and expects the bit to drop. Hidden flags are another difficulty: a flagged source whose enable is 0 cannot be seen at the ports. The bench therefore disables such a source, leaves it alone, and then re-enables it, so the latched flag becomes visible on the identification byte.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    typedef enum logic {
        WK_LOAD_EN = 1'b0,
        WK_CLEAR   = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/irq_grp_store.sv
module irq_grp_store
    import irq_pend_pkg::*;
#(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             wr_hit_i,
    input  logic             wr_clr_i,
    input  logic [SRC_W-1:0] wr_data_i,
    output logic [SRC_W-1:0] flag_o,
    output logic             pend_o
);
    typedef struct packed {
        logic [SRC_W-1:0] flag;
        logic [SRC_W-1:0] en;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i && wr_clr_i == WK_CLEAR) begin
            st_d.flag = st_q.flag & ~wr_data_i;
        end
        if (wr_hit_i && wr_clr_i == WK_LOAD_EN) begin
            st_d.en = wr_data_i;
        end
        // hardware set applied last so it wins over a clear
        st_d.flag = st_d.flag | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign pend_o = |(st_q.flag & st_q.en);
endmodule

// File: rtl/irq_sys_store.sv
module irq_sys_store
    import irq_pend_pkg::*;
#(
    parameter int SYS_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SYS_SRC-1:0] evt_i,
    input  logic               wr_hit_i,
    input  logic               wr_clr_i,
    input  logic [SYS_SRC-1:0] wr_bits_i,
    input  logic               wr_gie_i,
    output logic               pend_o
);
    typedef struct packed {
        logic               gie;
        logic [SYS_SRC-1:0] flag;
        logic [SYS_SRC-1:0] en;
    } sys_st_t;

    sys_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i && wr_clr_i == WK_CLEAR) begin
            st_d.flag = st_q.flag & ~wr_bits_i;
        end
        if (wr_hit_i && wr_clr_i == WK_LOAD_EN) begin
            st_d.en  = wr_bits_i;
            st_d.gie = wr_gie_i;
        end
        st_d.flag = st_d.flag | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.gie & (|(st_q.flag & st_q.en));
endmodule

// File: rtl/irq_id_reg.sv
module irq_id_reg #(
    parameter int NUM_GRP = 6,
    parameter int ID_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_pend_i,
    input  logic               sys_pend_i,
    output logic [ID_W-1:0]    id_o
);
    localparam int SYS_BIT = ID_W - 1;

    typedef struct packed {
        logic [ID_W-1:0] id;
    } id_st_t;

    id_st_t st_d, st_q;

    always_comb begin
        st_d.id                = '0;
        st_d.id[NUM_GRP-1:0]   = grp_pend_i;
        st_d.id[SYS_BIT]       = sys_pend_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_o = st_q.id;
endmodule

// File: rtl/irq_pend_id.sv
module irq_pend_id
    import irq_pend_pkg::*;
#(
    parameter int NUM_GRP = 6,
    parameter int SRC_W   = 8,
    parameter int SYS_SRC = 4,
    parameter int SEL_W   = 3,
    parameter int ID_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*SRC_W-1:0] evt_i,
    input  logic [SYS_SRC-1:0]       sys_evt_i,
    input  logic                     wr_en_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  logic                     wr_clr_i,
    input  logic [SRC_W-1:0]         wr_data_i,
    output logic [ID_W-1:0]          id_o
);
    localparam logic [SEL_W-1:0] SYS_SEL = SEL_W'(NUM_GRP);
    localparam int               GIE_BIT = SRC_W - 1;

    logic [NUM_GRP-1:0]       grp_pend;
    logic [NUM_GRP*SRC_W-1:0] flag_all;
    logic                     sys_pend;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
        irq_grp_store #(.SRC_W(SRC_W)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[g*SRC_W +: SRC_W]),
            .wr_hit_i  (wr_en_i && wr_sel_i == MY_SEL),
            .wr_clr_i  (wr_clr_i),
            .wr_data_i (wr_data_i),
            .flag_o    (flag_all[g*SRC_W +: SRC_W]),
            .pend_o    (grp_pend[g])
        );
    end

    irq_sys_store #(.SYS_SRC(SYS_SRC)) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (sys_evt_i),
        .wr_hit_i  (wr_en_i && wr_sel_i == SYS_SEL),
        .wr_clr_i  (wr_clr_i),
        .wr_bits_i (wr_data_i[SYS_SRC-1:0]),
        .wr_gie_i  (wr_data_i[GIE_BIT]),
        .pend_o    (sys_pend)
    );

    irq_id_reg #(.NUM_GRP(NUM_GRP), .ID_W(ID_W)) u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_pend_i (grp_pend),
        .sys_pend_i (sys_pend),
        .id_o       (id_o)
    );
endmodule

// File: rtl/irq_pend_id_chk.sv
module irq_pend_id_chk #(
    parameter int NUM_GRP = 6,
    parameter int SRC_W   = 8,
    parameter int SEL_W   = 3,
    parameter int ID_W    = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_GRP*SRC_W-1:0] evt_i,
    input logic                     wr_en_i,
    input logic [SEL_W-1:0]         wr_sel_i,
    input logic                     wr_clr_i,
    input logic [SRC_W-1:0]         wr_data_i,
    input logic [NUM_GRP*SRC_W-1:0] flag_all,
    input logic [ID_W-1:0]          id_o
);
    localparam int HOLE_BIT = ID_W - 2;

    a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        id_o[HOLE_BIT] == 1'b0);

    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> id_o == '0);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);

        a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_i[g*SRC_W +: SRC_W]) |=>
            ((flag_all[g*SRC_W +: SRC_W] & $past(evt_i[g*SRC_W +: SRC_W]))
              == $past(evt_i[g*SRC_W +: SRC_W])));

        a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_sel_i == MY_SEL && wr_clr_i) |=>
            ((flag_all[g*SRC_W +: SRC_W]
              & $past(wr_data_i & ~evt_i[g*SRC_W +: SRC_W])) == '0));

        a_r3_pend_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            id_o[g] |-> $past(|flag_all[g*SRC_W +: SRC_W]));
    end
endmodule

bind irq_pend_id irq_pend_id_chk #(
    .NUM_GRP(NUM_GRP), .SRC_W(SRC_W), .SEL_W(SEL_W), .ID_W(ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_clr_i  (wr_clr_i),
    .wr_data_i (wr_data_i),
    .flag_all  (flag_all),
    .id_o      (id_o)
);

// File: tb/irq_pend_id_test.sv
`timescale 1ns/1ps
module irq_pend_id_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] evt_i;
    logic [3:0]  sys_evt_i;
    logic        wr_en_i;
    logic [2:0]  wr_sel_i;
    logic        wr_clr_i;
    logic [7:0]  wr_data_i;
    logic [7:0]  id_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_pend_id uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sys_evt_i(sys_evt_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_clr_i(wr_clr_i),
        .wr_data_i(wr_data_i), .id_o(id_o)
    );

    typedef struct packed {
        logic [47:0] evt;
        logic [3:0]  sevt;
        logic        we;
        logic [2:0]  sel;
        logic        clr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{48'h0,            4'h0, 1'b1, 3'd0, 1'b0, 8'hFF, 8'h00, 4'd11}, // R11 load en g0
        '{48'h8,            4'h0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01, 4'd1},  // R1
        '{48'h1_0000,       4'h0, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01, 4'd3},  // R3
        '{48'h0,            4'h0, 1'b1, 3'd2, 1'b0, 8'h01, 8'h05, 4'd1},  // R1
        '{48'h0,            4'h0, 1'b1, 3'd2, 1'b1, 8'h01, 8'h01, 4'd5},  // R5
        '{48'h0,            4'h0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 4'd4},  // R4
        '{48'h0,            4'h0, 1'b1, 3'd0, 1'b0, 8'h08, 8'h01, 4'd8},  // R8
        '{48'h0,            4'h0, 1'b1, 3'd0, 1'b1, 8'hF7, 8'h01, 4'd5},  // R5
        '{48'h8000_0000_0000,4'h0,1'b1, 3'd5, 1'b0, 8'hFF, 8'h21, 4'd1},  // R1
        '{48'h0,            4'h2, 1'b1, 3'd6, 1'b0, 8'h02, 8'h21, 4'd10}, // R10
        '{48'h0,            4'h0, 1'b1, 3'd6, 1'b0, 8'h82, 8'hA1, 4'd2},  // R2
        '{48'h0,            4'h0, 1'b1, 3'd7, 1'b1, 8'hFF, 8'hA1, 4'd11}, // R11
        '{48'h8000_0000_0000,4'h0,1'b1, 3'd5, 1'b1, 8'hFF, 8'hA1, 4'd9},  // R9
        '{48'h0,            4'h0, 1'b1, 3'd5, 1'b1, 8'hFF, 8'h81, 4'd5},  // R5
        '{48'h0,            4'h0, 1'b1, 3'd6, 1'b1, 8'h02, 8'h01, 4'd5}   // R5
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: id_o=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        evt_i = '0; sys_evt_i = '0; wr_en_i = 1'b0;
        wr_sel_i = '0; wr_clr_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        evt_i = v.evt; sys_evt_i = v.sevt; wr_en_i = v.we;
        wr_sel_i = v.sel; wr_clr_i = v.clr; wr_data_i = v.data;
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: id_o=%02h expected=done", id_o);
        finish_run();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset value", id_o, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check($sformatf("R%0d row %0d", TBL[i].req, i), id_o, TBL[i].exp);
            check("R6 hole bit", {7'b0, id_o[6]}, 8'h00);
        end

        // R1 latency: one edge after an event the byte is unchanged, after two it shows
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h10;
        @(negedge clk);
        idle();
        @(negedge clk);
        evt_i = 48'h1000;
        @(negedge clk);
        idle();
        check("R1 latency one edge", id_o, 8'h01);
        @(negedge clk);
        check("R1 latency two edges", id_o, 8'h03);

        // R7 reset mid-run clears flags and enables
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset mid-run", id_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'hFF;
        @(negedge clk);
        wr_sel_i = 3'd6; wr_data_i = 8'h8F;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R7 flags cleared by reset", id_o, 8'h00);

        // R10 system pending drops when global enable is cleared
        sys_evt_i = 4'h8;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R2 system pending", id_o, 8'h80);
        wr_en_i = 1'b1; wr_sel_i = 3'd6; wr_data_i = 8'h0F;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R10 global enable off", id_o, 8'h00);

        finish_run();
    end
endmodule